// File: doc/BRIEF.md
# Granular Memory Protection Address Entry

This block holds one address entry of a physical memory protection unit, together with the logic that decides whether a request address falls inside the region the entry describes. The entry is written and read through a CSR-style port. The region shape comes from a two-bit mode input, which selects disabled, top-of-range, naturally aligned four-byte or naturally aligned power-of-two. In top-of-range mode the lower bound is the address of the previous entry, which arrives on its own input.

The protection granule is 2^(Gran+2) bytes. The entry keeps only the address bits that this granule allows. When it is read, it fills the low bits with the values that the current mode implies. The match logic works on that same read-back value, so software always sees the address that is actually used for matching. Permissions across entries and lock handling sit outside this block.

All addresses on the CSR side are word addresses: bit i of an entry value stands for byte-address bit i+2. The request address is a byte address.

Top module: `pmp_addr_entry`

## Requirements
- R1: After reset the stored address is zero. A write stores bits [AddrW-1:Gran-1] of the write data (all bits when Gran is 0), and the read value shows them from the next cycle. Lower written bits are discarded.
- R2: Mode encoding is 0 = OFF, 1 = TOR, 2 = NA4, 3 = NAPOT. In OFF and TOR, read bits [Gran-1:0] are zero.
- R3: In NA4 and NAPOT, read bits [Gran-2:0] are ones, and read bit Gran-1 is the stored bit.
- R4: A mode change alters the read value and the match behaviour immediately, without a rewrite. The entry is always matched using its read value.
- R5: In OFF mode the match output is always 0.
- R6: In TOR mode the match output is 1 exactly when prev <= word(req) < entry. Here prev is the previous entry's address with bits [Gran-1:0] cleared, and word(req) is the request address shifted right by 2. If prev >= entry, nothing matches.
- R7: In NAPOT mode, let k be the number of trailing ones in the read value. The region is the 2^(k+3)-byte aligned block that contains the read value times 4. An all-ones read value matches every address.
- R8: With Gran > 0, a NAPOT entry whose stored bit Gran-1 is 0 covers exactly one granule of 2^(Gran+2) bytes.
- R9: NA4 mode never matches when Gran > 0. When Gran is 0, it matches the single 4-byte word at the entry address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrWrEn | input | 1 | Write strobe for the entry |
| csrWrData | input | AddrW | Write data (word address) |
| entryMode | input | 2 | Region mode: 0 OFF, 1 TOR, 2 NA4, 3 NAPOT |
| prevAddr | input | AddrW | Previous entry's address, lower bound in TOR |
| reqAddr | input | AddrW+2 | Byte address to be checked |
| csrRdData | output | AddrW | Architectural read value of the entry |
| match | output | 1 | Request address lies inside the region |

## Verification
The hardest case to reach is a NAPOT region that spans exactly one granule. It needs a written value whose bit Gran-1 is zero and whose lower bits are discarded. Only the read-back fill of ones then produces the single-granule mask. The bench writes a value with bit Gran-1 clear and garbage in bit 0, switches to NAPOT, and probes the first and last byte of the granule and one byte on each side. It also writes one value once and reads it under TOR and under NAPOT. This shows that the same stored bits yield both the zero-filled bound and the one-filled region.

// File: rtl/pmp_entry_pkg.sv
package pmp_entry_pkg;

  typedef enum logic [1:0] {
    ModeOff   = 2'd0,
    ModeTor   = 2'd1,
    ModeNa4   = 2'd2,
    ModeNapot = 2'd3
  } pmp_mode_e;

  typedef struct packed {
    logic torEn;
    logic na4En;
    logic napotEn;
    logic fillOnes;
  } pmp_strobe_t;

endpackage

// File: rtl/pmp_mode_ctrl.sv
module pmp_mode_ctrl
  import pmp_entry_pkg::*;
#(
  parameter int Gran = 2
) (
  input  logic [1:0]  entryMode,
  output pmp_strobe_t strb
);

  localparam bit Na4Legal = (Gran == 0);

  pmp_mode_e modeSel;

  always_comb begin
    modeSel       = pmp_mode_e'(entryMode);
    strb          = '0;
    strb.fillOnes = entryMode[1];
    unique case (modeSel)
      ModeTor:   strb.torEn   = 1'b1;
      ModeNa4:   strb.na4En   = Na4Legal;
      ModeNapot: strb.napotEn = 1'b1;
      default:   strb         = '0;
    endcase
  end

endmodule

// File: rtl/pmp_addr_dp.sv
module pmp_addr_dp
  import pmp_entry_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int Gran  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AddrW-1:0]  wrData,
  input  pmp_strobe_t       strb,
  input  logic [AddrW-1:0]  prevAddr,
  input  logic [AddrW+1:0]  reqAddr,
  output logic [AddrW-1:0]  rdData,
  output logic              match
);

  localparam int StoreLsb = (Gran == 0) ? 0 : Gran - 1;
  localparam int StoreW   = AddrW - StoreLsb;
  localparam logic [AddrW-1:0] AlignMask = {AddrW{1'b1}} << Gran;

  logic [StoreW-1:0] addrQ;
  logic [AddrW-1:0]  napotMask;
  logic [AddrW-1:0]  reqWord;
  logic [AddrW-1:0]  torLo;
  logic              torHit;
  logic              napotHit;
  logic              na4Hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (wrEn) begin
      addrQ <= wrData[AddrW-1:StoreLsb];
    end
  end

  generate
    if (Gran == 0) begin : g_full
      assign rdData = addrQ;
    end else begin : g_gran
      always_comb begin
        rdData = '0;
        rdData[AddrW-1:StoreLsb] = addrQ;
        for (int i = 0; i < StoreLsb; i++) begin
          rdData[i] = strb.fillOnes;
        end
        if (!strb.fillOnes) begin
          rdData[StoreLsb] = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    napotMask[0] = 1'b0;
    for (int i = 1; i < AddrW; i++) begin
      napotMask[i] = napotMask[i-1] | ~rdData[i-1];
    end
  end

  assign reqWord  = reqAddr[AddrW+1:2];
  assign torLo    = prevAddr & AlignMask;
  assign torHit   = (torLo <= reqWord) && (reqWord < rdData);
  assign napotHit = ((reqWord ^ rdData) & napotMask) == '0;
  assign na4Hit   = (reqWord == rdData);

  assign match = (strb.torEn & torHit) | (strb.napotEn & napotHit) |
                 (strb.na4En & na4Hit);

  p_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[AddrW-1:Gran] == $past(wrData[AddrW-1:Gran]));

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.torEn | strb.na4En | strb.napotEn) |-> !match);

  p_tor_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.torEn && (torLo >= rdData)) |-> !match);

  p_napot_all_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.napotEn && (&rdData)) |-> match);

endmodule

// File: rtl/pmp_addr_entry.sv
module pmp_addr_entry
  import pmp_entry_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int Gran  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [AddrW-1:0] csrWrData,
  input  logic [1:0]       entryMode,
  input  logic [AddrW-1:0] prevAddr,
  input  logic [AddrW+1:0] reqAddr,
  output logic [AddrW-1:0] csrRdData,
  output logic             match
);

  pmp_strobe_t strb;

  pmp_mode_ctrl #(.Gran(Gran)) u_ctrl (
    .entryMode (entryMode),
    .strb      (strb)
  );

  pmp_addr_dp #(.AddrW(AddrW), .Gran(Gran)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (csrWrEn),
    .wrData   (csrWrData),
    .strb     (strb),
    .prevAddr (prevAddr),
    .reqAddr  (reqAddr),
    .rdData   (csrRdData),
    .match    (match)
  );

  generate
    if (Gran > 0) begin : g_chk
      p_low_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
        !entryMode[1] |-> csrRdData[Gran-1:0] == '0);

      p_na4_dead_r9: assert property (@(posedge clk) disable iff (!rstN)
        (entryMode == 2'd2) |-> !match);
    end
  endgenerate

endmodule

// File: tb/pmp_addr_entry_test.sv
module pmp_addr_entry_test;

  localparam int ClkPeriod = 10;
  localparam int AddrW = 16;
  localparam int Gran  = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             csrWrEn = 1'b0;
  logic [AddrW-1:0] csrWrData = '0;
  logic [1:0]       entryMode = 2'd0;
  logic [AddrW-1:0] prevAddr = '0;
  logic [AddrW+1:0] reqAddr = '0;
  logic [AddrW-1:0] csrRdData;
  logic             match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  pmp_addr_entry #(.AddrW(AddrW), .Gran(Gran)) uut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .entryMode(entryMode), .prevAddr(prevAddr), .reqAddr(reqAddr),
    .csrRdData(csrRdData), .match(match)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [AddrW-1:0] d);
    @(negedge clk);
    csrWrEn = 1'b1;
    csrWrData = d;
    @(negedge clk);
    csrWrEn = 1'b0;
    csrWrData = '0;
  endtask

  task automatic probe(input string req, input logic [AddrW+1:0] a, input logic exp);
    reqAddr = a;
    #1;
    check(req, {31'd0, match}, {31'd0, exp});
  endtask

  task automatic testReset();
    #1;
    check("R1 reset read", {16'd0, csrRdData}, 32'h0);
    probe("R5 reset off", 18'h0, 1'b0);
  endtask

  task automatic testReadFill();
    writeEntry(16'h1236);
    entryMode = 2'd1; #1;
    check("R2 tor read", {16'd0, csrRdData}, 32'h1234);
    entryMode = 2'd0; #1;
    check("R2 off read", {16'd0, csrRdData}, 32'h1234);
    entryMode = 2'd3; #1;
    check("R3 R4 napot read same store", {16'd0, csrRdData}, 32'h1237);
    entryMode = 2'd2; #1;
    check("R3 na4 read", {16'd0, csrRdData}, 32'h1237);
    writeEntry(16'hABC8);
    entryMode = 2'd3; #1;
    check("R1 R3 low bit discarded", {16'd0, csrRdData}, 32'hABC9);
  endtask

  task automatic testNapot();
    entryMode = 2'd3;
    writeEntry(16'h1237);
    probe("R7 base", 18'h048C0, 1'b1);
    probe("R7 top", 18'h048FF, 1'b1);
    probe("R7 above", 18'h04900, 1'b0);
    probe("R7 below", 18'h048BF, 1'b0);
    writeEntry(16'hFFFF);
    probe("R7 all ones low", 18'h00000, 1'b1);
    probe("R7 all ones high", 18'h3FFFF, 1'b1);
  endtask

  task automatic testGranule();
    entryMode = 2'd3;
    writeEntry(16'h1235);
    check("R8 read", {16'd0, csrRdData}, 32'h1235);
    probe("R8 first byte", 18'h048D0, 1'b1);
    probe("R8 last byte", 18'h048DF, 1'b1);
    probe("R8 next granule", 18'h048E0, 1'b0);
    probe("R8 prev granule", 18'h048CF, 1'b0);
  endtask

  task automatic testTor();
    entryMode = 2'd1;
    prevAddr = 16'h1003;
    writeEntry(16'h1236);
    probe("R6 low bound", 18'h04000, 1'b1);
    probe("R6 below low", 18'h03FFF, 1'b0);
    probe("R4 R6 last in", 18'h048CF, 1'b1);
    probe("R6 at top", 18'h048D0, 1'b0);
    prevAddr = 16'h2000;
    probe("R6 empty range", 18'h048C0, 1'b0);
  endtask

  task automatic testOffNa4();
    prevAddr = 16'h0000;
    writeEntry(16'h1234);
    entryMode = 2'd0;
    probe("R5 off", 18'h048D0, 1'b0);
    entryMode = 2'd2;
    probe("R9 na4 exact word", 18'h048D0, 1'b0);
    probe("R9 na4 other", 18'h048D4, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReadFill();
    testNapot();
    testGranule();
    testTor();
    testOffNa4();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule